// File: doc/BRIEF.md
# Single-Operand Shift and Extend ALU

This execution unit applies one of four single-operand transforms to a 16-bit value: rotate right through carry, byte swap, arithmetic shift right, and sign extension of the low byte to a full word. A one-cycle `start_i` pulse launches an operation with the operand, a 3-bit opcode, a byte/word select and the current status flags. One clock later the unit presents the result, the new status flags and a `done_o` pulse.

The two shifts honour the byte/word select. In byte mode they act on bits 7:0, take the sign from bit 7 and clear the upper byte. Byte swap and sign extension always work on the whole word. Each operation has its own rule for updating the flags. Opcodes outside the supported set return the operand and flags unchanged and raise `unsupported_o`. Between launches the outputs hold their last values.

Top module: `shalu_top`

## Requirements
- R1: After reset deasserts, `result_o` is 0, `flags_o` is 0, `done_o` is 0 and `unsupported_o` is 0.
- R2: `done_o` is high in exactly the cycle after a cycle with `start_i` high. `result_o`, `flags_o` and `unsupported_o` update only then. Otherwise they hold their values.
- R3: Opcode 0 (rotate right through carry) shifts the active width right by one. Incoming C (`flags_i[1]`) enters bit 15 in word mode and bit 7 in byte mode (`byte_i`=1).
- R4: Opcode 2 (arithmetic shift right) shifts the active width right by one and keeps its MSB. The MSB is bit 15 in word mode and bit 7 in byte mode.
- R5: The flag vector is N=bit 3, Z=bit 2, C=bit 1, V=bit 0. For opcodes 0 and 2, C is operand bit 0, N is the result MSB at the active width, Z is set when the result is zero, and V is 0.
- R6: Opcode 1 returns `{operand[7:0], operand[15:8]}` whatever `byte_i` is, and `flags_o` equals `flags_i`.
- R7: Opcode 3 returns operand bits 7:0 with bit 7 copied into bits 15:8, whatever `byte_i` is. N is result bit 15, Z is set for a zero result, C is the inverse of Z, and V is 0.
- R8: In byte mode, opcodes 0 and 2 drive result bits 15:8 to zero.
- R9: Opcodes 4 to 7 return the operand and `flags_i` unchanged with `unsupported_o` high. Opcodes 0 to 3 set `unsupported_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch strobe, one cycle |
| op_i | input | 3 | Opcode |
| byte_i | input | 1 | 1 = byte width, 0 = word width |
| operand_i | input | 16 | Source operand |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| result_o | output | 16 | Registered result |
| flags_o | output | 4 | Registered flags {N,Z,C,V} |
| done_o | output | 1 | Result valid strobe |
| unsupported_o | output | 1 | Opcode outside 0 to 3 |

## Verification
The assertions assume that `op_i`, `byte_i`, `operand_i` and `flags_i` are stable and known in every cycle in which `start_i` is high. They assume no such relation in other cycles. The bench changes inputs only on the falling clock edge, raises `start_i` for one cycle per operation, and drops it before the next sample. Because of this, each launch is captured by exactly one rising edge, and the hold checks see cycles with `start_i` low.

// File: rtl/shalu_pkg.sv
package shalu_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_RRC  = 3'd0,
    OP_SWAP = 3'd1,
    OP_RRA  = 3'd2,
    OP_SXT  = 3'd3
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/shalu_shift.sv
module shalu_shift
  import shalu_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  localparam int unsigned H = W / 2
) (
  input  logic [W-1:0] operand_i,
  input  logic         byte_i,
  input  logic         arith_i,
  input  logic         cin_i,
  output logic [W-1:0] result_o,
  output flags_t       flags_o
);
  logic msb_in;

  always_comb begin
    result_o = '0;
    if (byte_i) begin
      msb_in = arith_i ? operand_i[H-1] : cin_i;
      result_o[H-1:0] = {msb_in, operand_i[H-1:1]};
      flags_o.n = result_o[H-1];
    end else begin
      msb_in = arith_i ? operand_i[W-1] : cin_i;
      result_o = {msb_in, operand_i[W-1:1]};
      flags_o.n = result_o[W-1];
    end
    flags_o.z = (result_o == '0);
    flags_o.c = operand_i[0];
    flags_o.v = 1'b0;
  end
endmodule

// File: rtl/shalu_swapext.sv
module shalu_swapext
  import shalu_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  localparam int unsigned H = W / 2
) (
  input  logic [W-1:0] operand_i,
  input  logic         sxt_i,
  input  flags_t       flags_i,
  output logic [W-1:0] result_o,
  output flags_t       flags_o
);
  always_comb begin
    if (sxt_i) begin
      result_o  = {{H{operand_i[H-1]}}, operand_i[H-1:0]};
      flags_o.n = result_o[W-1];
      flags_o.z = (result_o == '0);
      flags_o.c = ~flags_o.z;
      flags_o.v = 1'b0;
    end else begin
      result_o = {operand_i[H-1:0], operand_i[W-1:H]};
      flags_o  = flags_i;  // swap keeps status
    end
  end
endmodule

// File: rtl/shalu_top.sv
module shalu_top
  import shalu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [3:0]        flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        flags_o,
  output logic              done_o,
  output logic              unsupported_o
);
  flags_t            flg_in, sh_flg, sx_flg, nxt_flg;
  logic [DATA_W-1:0] sh_res, sx_res, nxt_res;
  logic              nxt_unsup;
  op_e               op;

  assign flg_in = flags_t'(flags_i);
  assign op     = op_e'(op_i);

  shalu_shift #(.W(DATA_W)) u_shift (
    .operand_i(operand_i),
    .byte_i   (byte_i),
    .arith_i  (op_i[1]),
    .cin_i    (flg_in.c),
    .result_o (sh_res),
    .flags_o  (sh_flg)
  );

  shalu_swapext #(.W(DATA_W)) u_swapext (
    .operand_i(operand_i),
    .sxt_i    (op_i[1]),
    .flags_i  (flg_in),
    .result_o (sx_res),
    .flags_o  (sx_flg)
  );

  always_comb begin
    nxt_unsup = 1'b0;
    unique case (op)
      OP_RRC, OP_RRA: begin nxt_res = sh_res; nxt_flg = sh_flg; end
      OP_SWAP, OP_SXT: begin nxt_res = sx_res; nxt_flg = sx_flg; end
      default: begin
        nxt_res   = operand_i;
        nxt_flg   = flg_in;
        nxt_unsup = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o      <= '0;
      flags_o       <= '0;
      done_o        <= 1'b0;
      unsupported_o <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        result_o      <= nxt_res;
        flags_o       <= nxt_flg;
        unsupported_o <= nxt_unsup;
      end
    end
  end

  assert_done_follows_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == $past(start_i));
  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(result_o) && $stable(flags_o) && $stable(unsupported_o)));
  assert_shift_v_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !op_i[2] && !op_i[0]) |=> (!flags_o[0] && flags_o[1] == $past(operand_i[0])));
  assert_swap_flags_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd1) |=> flags_o == $past(flags_i));
  assert_sxt_c_not_z_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd3) |=> (flags_o[1] == !flags_o[2] && !flags_o[0]));
  assert_byte_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && byte_i && !op_i[2] && !op_i[0]) |=> result_o[DATA_W-1:HALF_W] == '0);
  assert_unsup_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i[2]) |=> (unsupported_o && result_o == $past(operand_i)
                              && flags_o == $past(flags_i)));
  assert_sup_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !op_i[2]) |=> !unsupported_o);
endmodule

// File: tb/shalu_top_tb.sv
module shalu_top_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic        byte_m = 1'b0;
  logic [15:0] opnd = '0;
  logic [3:0]  flg = '0;
  logic [15:0] res;
  logic [3:0]  flg_o;
  logic        done, unsup;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shalu_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .byte_i(byte_m),
    .operand_i(opnd), .flags_i(flg), .result_o(res), .flags_o(flg_o),
    .done_o(done), .unsupported_o(unsup)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // launch one op, sample one cycle later on the falling edge
  task automatic run(input logic [2:0] o, input logic b, input logic [15:0] d,
                     input logic [3:0] f);
    @(negedge clk);
    op = o; byte_m = b; opnd = d; flg = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [15:0] r, input logic [3:0] f,
                            input logic u);
    chk(req, "done", {31'd0, done}, 32'd1);
    chk(req, "result", {16'd0, res}, {16'd0, r});
    chk(req, "flags", {28'd0, flg_o}, {28'd0, f});
    chk(req, "unsupported", {31'd0, unsup}, {31'd0, u});
  endtask

  task automatic t_reset();
    chk("R1", "result", {16'd0, res}, 32'd0);
    chk("R1", "flags", {28'd0, flg_o}, 32'd0);
    chk("R1", "done", {31'd0, done}, 32'd0);
    chk("R1", "unsupported", {31'd0, unsup}, 32'd0);
  endtask

  task automatic t_rrc();
    run(3'd0, 1'b0, 16'h0001, 4'b0000); expect_out("R3 R5", 16'h0000, 4'b0110, 1'b0);
    run(3'd0, 1'b0, 16'h2468, 4'b0010); expect_out("R3 R5", 16'h9234, 4'b1000, 1'b0);
    run(3'd0, 1'b1, 16'h12FE, 4'b0010); expect_out("R3 R8", 16'h00FF, 4'b1000, 1'b0);
    run(3'd0, 1'b1, 16'hFF01, 4'b1101); expect_out("R3 R8", 16'h0000, 4'b0110, 1'b0);
  endtask

  task automatic t_rra();
    run(3'd2, 1'b0, 16'h8001, 4'b0000); expect_out("R4 R5", 16'hC000, 4'b1010, 1'b0);
    run(3'd2, 1'b0, 16'h4002, 4'b0011); expect_out("R4 R5", 16'h2001, 4'b0000, 1'b0);
    run(3'd2, 1'b1, 16'hAA80, 4'b0010); expect_out("R4 R8", 16'h00C0, 4'b1000, 1'b0);
    run(3'd2, 1'b1, 16'h8001, 4'b0000); expect_out("R4 R8", 16'h0000, 4'b0110, 1'b0);
  endtask

  task automatic t_swap();
    run(3'd1, 1'b0, 16'h1234, 4'b1011); expect_out("R6", 16'h3412, 4'b1011, 1'b0);
    run(3'd1, 1'b1, 16'hABCD, 4'b0100); expect_out("R6", 16'hCDAB, 4'b0100, 1'b0);
  endtask

  task automatic t_sxt();
    run(3'd3, 1'b0, 16'h1280, 4'b0001); expect_out("R7", 16'hFF80, 4'b1010, 1'b0);
    run(3'd3, 1'b1, 16'hAB00, 4'b0011); expect_out("R7", 16'h0000, 4'b0100, 1'b0);
    run(3'd3, 1'b0, 16'hFF7F, 4'b1000); expect_out("R7", 16'h007F, 4'b0010, 1'b0);
  endtask

  task automatic t_unsup();
    for (int o = 4; o < 8; o++) begin
      run(o[2:0], o[0], 16'hBEEF ^ 16'(o), 4'b0101);
      expect_out("R9", 16'hBEEF ^ 16'(o), 4'b0101, 1'b1);
    end
    run(3'd1, 1'b0, 16'h00FF, 4'b0000); expect_out("R9", 16'hFF00, 4'b0000, 1'b0);
  endtask

  task automatic t_hold();
    run(3'd0, 1'b0, 16'h0004, 4'b0000);
    @(negedge clk);
    op = 3'd3; opnd = 16'h0080; flg = 4'b1111; byte_m = 1'b1;
    @(negedge clk);
    chk("R2", "done idle", {31'd0, done}, 32'd0);
    chk("R2", "result held", {16'd0, res}, 32'h0002);
    chk("R2", "flags held", {28'd0, flg_o}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rrc();
    t_rra();
    t_swap();
    t_sxt();
    t_unsup();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule